// File: doc/BRIEF.md
# VLIW Fetch-Packet Dispatch Unit

This block sits between instruction memory and the eight functional units of a wide-issue core. It pulls one 256-bit fetch packet at a time through a request/response handshake and holds it in a local buffer. It then cuts the buffer into variable-length execute packets and issues one of them per clock. The cuts are chosen by a link bit carried in each 32-bit instruction.

Every instruction in the issuing packet is steered to the functional unit named by a small field inside the instruction. That unit's valid flag is raised for the cycle. A stall input from downstream holds the issuing packet in place. A new fetch is only requested once the last execute packet of the buffered fetch packet has gone out.

Top module: `vliw_dispatch`

## Requirements
- R1: While reset is asserted, and while no fetch packet is buffered, every unit valid is low and the conflict flag is low. In the first cycle after reset is released with the stall input low, the fetch request is high.
- R2: Once raised, the fetch request stays high until a cycle in which the response-valid input is also high. In the cycle after that handshake, the request is low.
- R3: The response data is captured on the handshake edge, and the first execute packet appears on the outputs in the next cycle. Slot s of the packet is data bits [32s+31:32s], so slot 0 is the lowest 32 bits.
- R4: Slots are scanned upward from the current slot. An instruction whose bit 0 is 1 pulls the next slot into the same execute packet, and bit 0 equal to 0 closes the packet. Exactly one execute packet issues per cycle, so a fetch packet takes as many cycles as it has closing bits.
- R5: Bit 0 of slot 7 is treated as 0, so the last execute packet always ends with the fetch packet and never spills into the next one.
- R6: Bits [3:1] of an instruction give its destination unit u (0 to 7). The instruction appears on unit_instr_o[32u+31:32u] with unit_valid_o[u] high. Units with no instruction in the issuing packet show valid low and an all-zero instruction field.
- R7: If two or more instructions in one execute packet name the same unit, the lowest slot among them is delivered and conflict_o is high for that cycle.
- R8: No fetch request is raised while any execute packet of the buffered fetch packet is still to issue. The request rises in the cycle right after the last execute packet issues.
- R9: While the stall input is high, the issuing packet, its unit valids and its instructions stay unchanged on the outputs. No new fetch request is raised during a stall.
- R10: Asserting reset at any time discards the buffered packet at once. After release, the block fetches a fresh packet and restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Holds dispatch and blocks new fetch requests |
| fetch_req_o | output | 1 | Fetch request to instruction memory |
| fetch_ack_i | input | 1 | Response valid; completes the handshake |
| fetch_data_i | input | 256 | Fetch packet, slot 0 in the lowest 32 bits |
| unit_valid_o | output | 8 | Per-unit instruction valid |
| unit_instr_o | output | 256 | Per-unit instruction, unit u at bits [32u+31:32u] |
| conflict_o | output | 1 | Two instructions of the issuing packet target one unit |

## Verification
A slot pointer that goes wrong shows up in the same cycle as a valid mask or instruction field that does not match the expected packet. It also shows up at the end of the fetch packet as a wrong count of issue cycles. A control state that goes wrong shows up as a fetch request that arrives early, late, or during a stall, within one cycle of the faulty transition. The bench runs a model built from the requirements over fetch packets with all-short, all-linked, mixed and conflicting chains, and compares every issue cycle. Directed cases cover stalls, request holding and reset during dispatch.

// File: rtl/vliw_dispatch_pkg.sv
package vliw_dispatch_pkg;
  typedef enum logic [1:0] {
    FC_IDLE  = 2'd0,
    FC_REQ   = 2'd1,
    FC_ISSUE = 2'd2
  } fc_state_e;
endpackage

// File: rtl/vliw_chain_scan.sv
module vliw_chain_scan #(
  parameter int N_SLOTS = 8,
  localparam int PTR_W = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0] link_i,
  input  logic [PTR_W-1:0]   ptr_i,
  output logic [N_SLOTS-1:0] member_o,
  output logic [PTR_W-1:0]   next_ptr_o,
  output logic               last_o
);
  logic [PTR_W-1:0] end_idx;
  logic             open_c;
  logic             closed_c;

  always_comb begin
    open_c   = 1'b0;
    closed_c = 1'b0;
    member_o = '0;
    end_idx  = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (!closed_c && PTR_W'(i) == ptr_i) open_c = 1'b1;
      member_o[i] = open_c;
      // last slot always closes the packet
      if (open_c && (!link_i[i] || i == N_SLOTS-1)) begin
        end_idx  = PTR_W'(i);
        open_c   = 1'b0;
        closed_c = 1'b1;
      end
    end
  end

  assign last_o     = (end_idx == PTR_W'(N_SLOTS-1));
  assign next_ptr_o = end_idx + PTR_W'(1);
endmodule

// File: rtl/vliw_unit_router.sv
module vliw_unit_router #(
  parameter int N_SLOTS  = 8,
  parameter int N_UNITS  = 8,
  parameter int SLOT_W   = 32,
  parameter int UNIT_LSB = 1,
  localparam int UNIT_W  = $clog2(N_UNITS)
) (
  input  logic [N_SLOTS*SLOT_W-1:0] slots_i,
  input  logic [N_SLOTS-1:0]        member_i,
  output logic [N_UNITS-1:0]        unit_valid_o,
  output logic [N_UNITS*SLOT_W-1:0] unit_instr_o,
  output logic                      conflict_o
);
  logic [N_UNITS-1:0] dup_vec;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic              hit;
    logic              dup;
    logic [SLOT_W-1:0] ins;
    always_comb begin
      hit = 1'b0;
      dup = 1'b0;
      ins = '0;
      // lowest slot wins
      for (int i = 0; i < N_SLOTS; i++) begin
        if (member_i[i] && slots_i[i*SLOT_W+UNIT_LSB +: UNIT_W] == UNIT_W'(u)) begin
          if (hit) dup = 1'b1;
          else begin
            hit = 1'b1;
            ins = slots_i[i*SLOT_W +: SLOT_W];
          end
        end
      end
    end
    assign unit_valid_o[u]                   = hit;
    assign unit_instr_o[u*SLOT_W +: SLOT_W]  = ins;
    assign dup_vec[u]                        = dup;
  end

  assign conflict_o = |dup_vec;
endmodule

// File: rtl/vliw_fetch_ctrl.sv
module vliw_fetch_ctrl
  import vliw_dispatch_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = 32,
  localparam int PTR_W  = $clog2(N_SLOTS),
  localparam int PKT_W  = N_SLOTS * SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic             fetch_ack_i,
  input  logic [PKT_W-1:0] fetch_data_i,
  input  logic             last_i,
  input  logic [PTR_W-1:0] next_ptr_i,
  output logic             fetch_req_o,
  output logic             issuing_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PKT_W-1:0] pkt_o
);
  fc_state_e        state_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PKT_W-1:0] pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FC_IDLE;
      ptr_q   <= '0;
      pkt_q   <= '0;
    end else begin
      unique case (state_q)
        FC_IDLE:  if (!stall_i) state_q <= FC_REQ;
        FC_REQ: if (fetch_ack_i) begin
          state_q <= FC_ISSUE;
          pkt_q   <= fetch_data_i;
          ptr_q   <= '0;
        end
        FC_ISSUE: if (!stall_i) begin
          if (last_i) state_q <= FC_REQ;
          else        ptr_q   <= next_ptr_i;
        end
        default: state_q <= FC_IDLE;
      endcase
    end
  end

  assign fetch_req_o = (state_q == FC_REQ);
  assign issuing_o   = (state_q == FC_ISSUE);
  assign ptr_o       = ptr_q;
  assign pkt_o       = pkt_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_ack_i |=> fetch_req_o); // R2
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_ack_i |=> !fetch_req_o); // R2
  AST_ISSUE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_ack_i |=> issuing_o && ptr_q == '0); // R3
  AST_NO_EARLY_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issuing_o && !last_i |=> !fetch_req_o); // R8
  AST_REFETCH_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issuing_o && !stall_i && last_i |=> fetch_req_o); // R8
  AST_STALL_HOLD_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issuing_o && stall_i |=> issuing_o && $stable(ptr_q)); // R9
  AST_STALL_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_req_o && stall_i |=> !fetch_req_o); // R9
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import vliw_dispatch_pkg::*;
#(
  parameter int N_SLOTS  = 8,
  parameter int N_UNITS  = 8,
  parameter int SLOT_W   = 32,
  parameter int UNIT_LSB = 1,
  localparam int PTR_W   = $clog2(N_SLOTS),
  localparam int PKT_W   = N_SLOTS * SLOT_W,
  localparam int OUT_W   = N_UNITS * SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  output logic             fetch_req_o,
  input  logic             fetch_ack_i,
  input  logic [PKT_W-1:0] fetch_data_i,
  output logic [N_UNITS-1:0] unit_valid_o,
  output logic [OUT_W-1:0] unit_instr_o,
  output logic             conflict_o
);
  logic             issuing;
  logic [PTR_W-1:0] ptr;
  logic [PKT_W-1:0] pkt;
  logic [N_SLOTS-1:0] link;
  logic [N_SLOTS-1:0] member_raw;
  logic [N_SLOTS-1:0] member;
  logic [PTR_W-1:0] next_ptr;
  logic             last;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_link
    assign link[s] = pkt[s*SLOT_W];
  end

  vliw_fetch_ctrl #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall_i),
    .fetch_ack_i  (fetch_ack_i),
    .fetch_data_i (fetch_data_i),
    .last_i       (last),
    .next_ptr_i   (next_ptr),
    .fetch_req_o  (fetch_req_o),
    .issuing_o    (issuing),
    .ptr_o        (ptr),
    .pkt_o        (pkt)
  );

  vliw_chain_scan #(.N_SLOTS(N_SLOTS)) u_scan (
    .link_i     (link),
    .ptr_i      (ptr),
    .member_o   (member_raw),
    .next_ptr_o (next_ptr),
    .last_o     (last)
  );

  assign member = member_raw & {N_SLOTS{issuing}};

  vliw_unit_router #(
    .N_SLOTS(N_SLOTS), .N_UNITS(N_UNITS), .SLOT_W(SLOT_W), .UNIT_LSB(UNIT_LSB)
  ) u_route (
    .slots_i      (pkt),
    .member_i     (member),
    .unit_valid_o (unit_valid_o),
    .unit_instr_o (unit_instr_o),
    .conflict_o   (conflict_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issuing |-> unit_valid_o == '0 && !conflict_o); // R1
  AST_ISSUE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issuing |-> unit_valid_o != '0); // R4
  AST_CONFLICT_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> $countones(unit_valid_o) < $countones(member)); // R7
  AST_NO_CONFLICT_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conflict_o |-> $countones(unit_valid_o) == $countones(member)); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i && unit_valid_o != '0 |=> $stable(unit_valid_o) && $stable(unit_instr_o)); // R9
endmodule

// File: tb/sim_vliw_dispatch.sv
module sim_vliw_dispatch;
  localparam int NPK = 6;
  localparam logic [23:0] T_UNITS [NPK] = '{24'o76543210, 24'o76543210, 24'o12345670,
                                            24'o76542133, 24'o01234567, 24'o70123456};
  localparam logic [7:0]  T_LINKS [NPK] = '{8'h00, 8'hFF, 8'h4D, 8'h01, 8'h7F, 8'h3F};
  localparam int          T_NEXP  [NPK] = '{8, 1, 4, 7, 1, 2};
  localparam int          T_NCONF [NPK] = '{0, 0, 0, 1, 0, 0};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         stall_i = 1'b0;
  logic         fetch_ack_i = 1'b0;
  logic [255:0] fetch_data_i = '0;
  logic         fetch_req_o;
  logic [7:0]   unit_valid_o;
  logic [255:0] unit_instr_o;
  logic         conflict_o;

  int checks = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  vliw_dispatch u0 (
    .clk_i, .rst_ni, .stall_i, .fetch_req_o, .fetch_ack_i, .fetch_data_i,
    .unit_valid_o, .unit_instr_o, .conflict_o
  );

  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic logic [255:0] build(input int idx);
    logic [255:0] p = '0;
    for (int s = 0; s < 8; s++)
      p[s*32 +: 32] = {8'(idx + 1), 20'(s * 3 + 7), T_UNITS[idx][3*s +: 3], T_LINKS[idx][s]};
    return p;
  endfunction

  task automatic model(input logic [255:0] p, input int ptr, output logic [7:0] v,
                       output logic [255:0] ins, output logic c, output int nxt);
    v = '0; ins = '0; c = 1'b0; nxt = 8;
    for (int s = ptr; s < 8; s++) begin
      int u = int'(p[s*32+1 +: 3]);
      if (v[u]) c = 1'b1;
      else begin
        v[u] = 1'b1;
        ins[u*32 +: 32] = p[s*32 +: 32];
      end
      if (!p[s*32] || s == 7) begin
        nxt = s + 1;
        break;
      end
    end
  endtask

  task automatic run_pkt(input int idx, input int stall_at, input int stall_len);
    logic [255:0] p = build(idx);
    logic [7:0]   ev;
    logic [255:0] ei;
    logic         ec;
    int           nxt;
    int           ptr = 0;
    int           n = 0;
    int           nconf = 0;
    chk(fetch_req_o === 1'b1, "R8 request up before packet", 256'(fetch_req_o), 256'd1);
    fetch_data_i = p;
    fetch_ack_i  = 1'b1;
    tick;
    fetch_ack_i  = 1'b0;
    fetch_data_i = '0;
    chk(fetch_req_o === 1'b0, "R2 request drops after handshake", 256'(fetch_req_o), 256'd0);
    while (ptr < 8) begin
      model(p, ptr, ev, ei, ec, nxt);
      chk(unit_valid_o === ev, "R4 R6 unit valid mask", 256'(unit_valid_o), 256'(ev));
      chk(unit_instr_o === ei, "R3 R6 unit instructions", unit_instr_o, ei);
      chk(conflict_o === ec, "R7 conflict flag", 256'(conflict_o), 256'(ec));
      chk(fetch_req_o === 1'b0, "R8 no fetch mid packet", 256'(fetch_req_o), 256'd0);
      if (n == stall_at) begin
        stall_i = 1'b1;
        for (int k = 0; k < stall_len; k++) begin
          tick;
          chk(unit_valid_o === ev && conflict_o === ec, "R9 valids frozen in stall", 256'(unit_valid_o), 256'(ev));
          chk(unit_instr_o === ei, "R9 instructions frozen in stall", unit_instr_o, ei);
          chk(fetch_req_o === 1'b0, "R9 no request in stall", 256'(fetch_req_o), 256'd0);
        end
        stall_i = 1'b0;
      end
      n++;
      if (ec) nconf++;
      ptr = nxt;
      tick;
    end
    chk(n == T_NEXP[idx], "R4 execute packet count", 256'(n), 256'(T_NEXP[idx]));
    if (idx == 1) chk(n == 1, "R5 slot 7 closes chain", 256'(n), 256'd1);
    chk(nconf == T_NCONF[idx], "R7 conflict cycles", 256'(nconf), 256'(T_NCONF[idx]));
    chk(fetch_req_o === 1'b1, "R8 refetch after last packet", 256'(fetch_req_o), 256'd1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick;
    tick;
    chk(unit_valid_o === 8'h00 && conflict_o === 1'b0, "R1 quiet in reset", 256'(unit_valid_o), 256'd0);
    chk(fetch_req_o === 1'b0, "R1 no request in reset", 256'(fetch_req_o), 256'd0);
    rst_ni = 1'b1;
    tick;
    chk(fetch_req_o === 1'b1, "R1 request after reset", 256'(fetch_req_o), 256'd1);
    chk(unit_valid_o === 8'h00, "R1 idle units without packet", 256'(unit_valid_o), 256'd0);
    for (int k = 0; k < 3; k++) begin
      tick;
      chk(fetch_req_o === 1'b1, "R2 request held without response", 256'(fetch_req_o), 256'd1);
    end

    for (int idx = 0; idx < NPK; idx++)
      run_pkt(idx, (idx == 2 || idx == 5) ? 1 : -1, 3);

    // stall held through reset release: no request
    stall_i = 1'b1;
    rst_ni  = 1'b0;
    tick;
    rst_ni  = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick;
      chk(fetch_req_o === 1'b0, "R9 no request while stalled idle", 256'(fetch_req_o), 256'd0);
    end
    stall_i = 1'b0;
    tick;
    chk(fetch_req_o === 1'b1, "R9 request after stall release", 256'(fetch_req_o), 256'd1);

    // reset in the middle of a packet
    fetch_data_i = build(0);
    fetch_ack_i  = 1'b1;
    tick;
    fetch_ack_i  = 1'b0;
    tick;
    chk(unit_valid_o === 8'h02, "R10 second packet before reset", 256'(unit_valid_o), 256'h02);
    rst_ni = 1'b0;
    #1;
    chk(unit_valid_o === 8'h00 && fetch_req_o === 1'b0, "R10 state discarded by reset",
        256'({fetch_req_o, unit_valid_o}), 256'd0);
    tick;
    rst_ni = 1'b1;
    tick;
    chk(fetch_req_o === 1'b1, "R10 fresh fetch after reset", 256'(fetch_req_o), 256'd1);
    run_pkt(3, -1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule